// File: doc/BRIEF.md
# Duplicate Tag Parity Error Logger

This block watches every duplicate-tag lookup that a memory-space reference triggers. Each lookup reads two tag banks. Every bank returns a 9-bit tag and a stored parity bit. While nothing has gone wrong, the block keeps a running record of the most recent lookup: the 8-bit store offset and the tag and parity bit from both banks. Software can read that record at any time through a 64-bit error-log register.

When a lookup shows bad parity in either bank, the block does three things. It records that lookup, sets an error flag and pulses an interrupt. From then on the record is frozen. If another parity error arrives before software has cleared the flag, a missed-error flag is set instead. While the missed-error flag is set, logging stays inhibited and no further interrupt is raised. Software clears either flag by writing 1 to it.

The register holds two lanes of 32 bits. The lanes use the same layout and work independently. Each lane has its own lookup inputs and its own interrupt.

Top module: `dtag_err_log`

## Requirements
- R1: Field positions within a lane: bit 0 is the missed-error flag and bit 1 is the error flag. Bits 9:2 hold the store offset, 18:10 the bank-0 tag and bit 19 the bank-0 parity. Bits 28:20 hold the bank-1 tag and bit 29 the bank-1 parity. The offset, tag and parity fields are read-only, so writes do not change them.
- R2: Lane 1 occupies bits 63:32 with the R1 layout shifted up by 32. Activity on one lane never changes the other lane's fields, flags or interrupt.
- R3: A valid lookup on a lane that is not frozen loads its offset, tags and parity bits. The new values are readable after the next rising clock edge.
- R4: Parity is even: a bank's parity bit is correct when it equals the XOR of that bank's 9 tag bits. A valid lookup with a wrong parity bit in either bank sets the error flag. The same clock edge records that lookup's data.
- R5: While the error flag is set and is not being cleared, the logged fields do not change.
- R6: A parity error that arrives while the lane is frozen sets the missed-error flag and raises no interrupt.
- R7: Writing 1 to a flag bit clears that flag. Writing 0 to a flag bit has no effect.
- R8: A synchronous active-low reset clears both flags and the interrupt in every lane.
- R9: The interrupt is high for exactly one cycle, together with the first rise of the error flag. Later errors do not raise it again until the flags are cleared.
- R10: A write-1 clear of the error flag and a new parity error in the same cycle leave the error flag set. The new lookup is recorded and the interrupt pulses.
- R11: While the missed-error flag is set, logging is inhibited even after the error flag alone has been cleared. Logging resumes once both flags are clear.
- R12: Bits 31:30 and 63:62 always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 2 | Per-lane lookup strobe from a memory-space reference |
| lk_offset | input | 16 | Per-lane store offset, 8 bits per lane |
| lk_tag0 | input | 18 | Per-lane bank-0 tag, 9 bits per lane |
| lk_par0 | input | 2 | Per-lane bank-0 stored parity |
| lk_tag1 | input | 18 | Per-lane bank-1 tag, 9 bits per lane |
| lk_par1 | input | 2 | Per-lane bank-1 stored parity |
| csr_wr | input | 1 | Register write strobe |
| csr_wdata | input | 64 | Register write data; only the flag bits act, as write-1-to-clear |
| csr_rdata | output | 64 | Error-log register contents |
| err_irq | output | 2 | Per-lane one-cycle interrupt on a newly logged error |

## Verification
The bench sweeps all 512 tag values through both banks and both lanes. A design that got the parity polarity wrong, or that swapped the layout of the two banks, would read back the wrong fields or flag false errors. It injects each single-bank and dual-bank error and then follows up with a second error. A design that left logging open, or that raised the interrupt again, would be caught either overwriting the frozen record or pulsing a second time. The bench also covers a clear that arrives in the same cycle as a new error, where a wrong priority drops the new error. Last, it clears only the error flag while missed-error stays set, where a design that checked the error flag alone would wrongly resume logging.

// File: rtl/dtag_log_pkg.sv
// Shared sizes and the captured-lookup record for the duplicate tag logger.
// Assumes a 32-bit lane: two flag bits, the record, and zero padding above it.
package dtag_log_pkg;
    localparam int OFF_W  = 8;
    localparam int TAG_W  = 9;
    localparam int LANE_W = 32;

    // Record of one lookup, packed LSB-first into lane bits 29:2.
    typedef struct packed {
        logic             par1;
        logic [TAG_W-1:0] tag1;
        logic             par0;
        logic [TAG_W-1:0] tag0;
        logic [OFF_W-1:0] off;
    } dtag_rec_t;

    localparam int REC_W = $bits(dtag_rec_t);
    localparam int PAD_W = LANE_W - REC_W - 2;
endpackage

// File: rtl/dtag_par_chk.sv
// Even-parity checker for the two tag banks of one lookup.
// Assumes a parity bit is correct when it equals the XOR of its tag bits.
// Purely combinational; bad is qualified by the lookup strobe.
module dtag_par_chk
    import dtag_log_pkg::*;
(
    input  logic      valid,
    input  dtag_rec_t rec,
    output logic      bad
);
    logic [1:0] bank_bad;

    // Compare each bank's stored parity with the parity recomputed from its tag.
    always_comb begin
        bank_bad[0] = (^rec.tag0) ^ rec.par0;
        bank_bad[1] = (^rec.tag1) ^ rec.par1;
        bad         = valid & (|bank_bad);
    end
endmodule

// File: rtl/dtag_log_lane.sv
// One logging lane: tracks the latest lookup, freezes on the first parity
// error, counts a second error as missed, and pulses an interrupt.
// Assumes the clear strobes are already qualified by the register write.
module dtag_log_lane
    import dtag_log_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      lk_valid,
    input  dtag_rec_t lk_rec,
    input  logic      par_bad,
    input  logic      clr_err,
    input  logic      clr_miss,
    output logic      err_q,
    output logic      miss_q,
    output dtag_rec_t rec_q,
    output logic      irq_q
);
    logic hold_err;
    logic hold_miss;
    logic frozen;
    logic take;

    // Flags surviving this cycle's clears decide whether the lane stays frozen.
    always_comb begin
        hold_err  = err_q & ~clr_err;
        hold_miss = miss_q & ~clr_miss;
        frozen    = hold_err | hold_miss;
        take      = lk_valid & ~frozen;
    end

    // Flag and interrupt state with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q  <= 1'b0;
            miss_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            err_q  <= hold_err | (par_bad & ~frozen);
            miss_q <= hold_miss | (par_bad & frozen);
            irq_q  <= par_bad & ~frozen;
        end
    end

    // Captured lookup record; has no defined reset value.
    always_ff @(posedge clk) begin
        if (take) begin
            rec_q <= lk_rec;
        end
    end

    p_hold_when_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !clr_err) |=> $stable(rec_q));
    p_irq_with_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> err_q);
    p_miss_after_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(miss_q) |-> $past(err_q));
    p_no_irq_when_missed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_q && !clr_miss) |=> !irq_q);
    p_irq_needs_lookup_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> $past(lk_valid));
endmodule

// File: rtl/dtag_err_log.sv
// Duplicate tag parity error log: one checker and one lane per logging lane,
// read back as a single register with one 32-bit lane slice each.
// Assumes writes act only on the flag bits (write 1 to clear).
module dtag_err_log
    import dtag_log_pkg::*;
#(
    parameter int NUM_LANES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_LANES-1:0]        lk_valid,
    input  logic [NUM_LANES*OFF_W-1:0]  lk_offset,
    input  logic [NUM_LANES*TAG_W-1:0]  lk_tag0,
    input  logic [NUM_LANES-1:0]        lk_par0,
    input  logic [NUM_LANES*TAG_W-1:0]  lk_tag1,
    input  logic [NUM_LANES-1:0]        lk_par1,
    input  logic                        csr_wr,
    input  logic [NUM_LANES*LANE_W-1:0] csr_wdata,
    output logic [NUM_LANES*LANE_W-1:0] csr_rdata,
    output logic [NUM_LANES-1:0]        err_irq
);
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        dtag_rec_t in_rec;
        dtag_rec_t log_rec;
        logic      bad;
        logic      err_f;
        logic      miss_f;

        // Gather this lane's slice of the lookup inputs into one record.
        always_comb begin
            in_rec.off  = lk_offset[g*OFF_W +: OFF_W];
            in_rec.tag0 = lk_tag0[g*TAG_W +: TAG_W];
            in_rec.par0 = lk_par0[g];
            in_rec.tag1 = lk_tag1[g*TAG_W +: TAG_W];
            in_rec.par1 = lk_par1[g];
        end

        dtag_par_chk u_chk (
            .valid (lk_valid[g]),
            .rec   (in_rec),
            .bad   (bad)
        );

        dtag_log_lane u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .lk_valid (lk_valid[g]),
            .lk_rec   (in_rec),
            .par_bad  (bad),
            .clr_err  (csr_wr & csr_wdata[g*LANE_W + 1]),
            .clr_miss (csr_wr & csr_wdata[g*LANE_W]),
            .err_q    (err_f),
            .miss_q   (miss_f),
            .rec_q    (log_rec),
            .irq_q    (err_irq[g])
        );

        // Lay out the lane slice: padding, record, error flag, missed flag.
        always_comb begin
            csr_rdata[g*LANE_W +: LANE_W] = {{PAD_W{1'b0}}, log_rec, err_f, miss_f};
        end
    end
endmodule

// File: tb/dtag_err_log_tb.sv
module dtag_err_log_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  v;
    logic [1:0][7:0] off;
    logic [1:0][8:0] t0, t1;
    logic [1:0]  p0, p1;
    logic        wr;
    logic [63:0] wdata;
    logic [63:0] rdata;
    logic [1:0]  irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic        m_err [2];
    logic        m_miss[2];
    logic        m_irq [2];
    logic        m_known[2];
    logic [27:0] m_rec [2];
    int          seq = 0;

    always #10 clk = ~clk;

    dtag_err_log u_dut (
        .clk(clk), .rst_n(rst_n), .lk_valid(v), .lk_offset(off),
        .lk_tag0(t0), .lk_par0(p0), .lk_tag1(t1), .lk_par1(p1),
        .csr_wr(wr), .csr_wdata(wdata), .csr_rdata(rdata), .err_irq(irq)
    );

    task automatic look(input int l, input int o, input int a, input int b,
                        input bit f0, input bit f1);
        v[l]   = 1'b1;
        off[l] = o[7:0];
        t0[l]  = a[8:0];
        t1[l]  = b[8:0];
        p0[l]  = (^a[8:0]) ^ f0;
        p1[l]  = (^b[8:0]) ^ f1;
    endtask

    task automatic check_all(input string req);
        for (int l = 0; l < 2; l++) begin
            logic [31:0] exp, msk, got;
            exp = {2'b00, m_rec[l], m_err[l], m_miss[l]};
            msk = m_known[l] ? 32'hFFFF_FFFF : 32'hC000_0003;
            got = rdata[l*32 +: 32];
            n_chk++;
            if (((got ^ exp) & msk) != 0) begin
                n_fail++;
                $display("FAIL %s lane%0d rdata actual=%h expected=%h mask=%h", req, l, got, exp, msk);
            end
            n_chk++;
            if (irq[l] !== m_irq[l]) begin
                n_fail++;
                $display("FAIL %s lane%0d irq actual=%b expected=%b", req, l, irq[l], m_irq[l]);
            end
        end
    endtask

    // Apply current drives over one rising edge, update the model, check at negedge.
    task automatic step(input string req);
        @(posedge clk);
        for (int l = 0; l < 2; l++) begin
            bit ce, cm, frz, bad;
            ce  = wr && wdata[l*32+1];
            cm  = wr && wdata[l*32];
            frz = (m_err[l] && !ce) || (m_miss[l] && !cm);
            bad = v[l] && (((^t0[l]) != p0[l]) || ((^t1[l]) != p1[l]));
            if (v[l] && !frz) begin
                m_rec[l]   = {p1[l], t1[l], p0[l], t0[l], off[l]};
                m_known[l] = 1'b1;
            end
            m_err[l]  = (m_err[l] && !ce) || (bad && !frz);
            m_miss[l] = (m_miss[l] && !cm) || (bad && frz);
            m_irq[l]  = bad && !frz;
        end
        @(negedge clk);
        check_all(req);
        v = '0; wr = 1'b0; wdata = '0;
    endtask

    task automatic other_good(input int l);
        seq++;
        look(l, seq * 7, seq * 13, seq * 29, 1'b0, 1'b0);
    endtask

    task automatic clr(input int l, input bit e, input bit m);
        wr = 1'b1;
        wdata = '0;
        wdata[l*32+1] = e;
        wdata[l*32]   = m;
    endtask

    initial begin
        rst_n = 1'b0; v = '0; off = '0; t0 = '0; t1 = '0; p0 = '0; p1 = '0;
        wr = 1'b0; wdata = '0;
        for (int l = 0; l < 2; l++) begin
            m_err[l] = 0; m_miss[l] = 0; m_irq[l] = 0; m_known[l] = 0; m_rec[l] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_all("R8");

        // R3/R2/R1/R12: every tag value through both banks of both lanes.
        for (int i = 0; i < 512; i++) begin
            look(0, i, i, 511 - i, 1'b0, 1'b0);
            look(1, 255 - i, (i * 37) % 512, i, 1'b0, 1'b0);
            step("R3");
        end

        // R1: data fields are read-only.
        wr = 1'b1; wdata = 64'hFFFF_FFFC_FFFF_FFFC;
        step("R1");

        // Error scenarios per lane, per erroring bank, across tag values.
        for (int l = 0; l < 2; l++) begin
            for (int b = 0; b < 3; b++) begin
                for (int k = 0; k < 4; k++) begin
                    int tg;
                    tg = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 255 : 511;
                    look(l, tg + 3, tg, 511 - tg, (b != 1), (b != 0));
                    other_good(1 - l);
                    step("R4");
                    look(l, tg + 9, 511 - tg, tg, (b == 0), (b == 1));
                    other_good(1 - l);
                    step("R6");
                    look(l, 77, 100 + k, 200 + k, 1'b0, 1'b0);
                    other_good(1 - l);
                    step("R5");
                    wr = 1'b1; wdata = '0;
                    step("R7");
                    clr(l, 1'b1, 1'b0);
                    step("R11");
                    look(l, 66, 300 + k, 400 + k, 1'b0, 1'b0);
                    step("R11");
                    look(l, 67, 301, 402, 1'b1, 1'b0);
                    step("R11");
                    clr(l, 1'b1, 1'b1);
                    step("R7");
                    look(l, 55, 12 + k, 34 + k, 1'b0, 1'b0);
                    step("R3");
                    look(l, 44, tg, tg, 1'b0, 1'b1);
                    step("R9");
                    step("R9");
                    clr(l, 1'b1, 1'b0);
                    look(l, 45, 511 - tg, tg, 1'b1, 1'b0);
                    other_good(1 - l);
                    step("R10");
                    clr(l, 1'b1, 1'b1);
                    step("R7");
                end
            end
        end

        // R2: both lanes error together, then clear lane 0 only.
        look(0, 1, 2, 3, 1'b1, 1'b0);
        look(1, 4, 5, 6, 1'b0, 1'b1);
        step("R2");
        clr(0, 1'b1, 1'b1);
        look(1, 8, 9, 10, 1'b0, 1'b0);
        step("R2");
        clr(1, 1'b1, 1'b1);
        step("R2");

        // R8: reset clears flags mid-error.
        look(0, 11, 12, 13, 1'b1, 1'b1);
        step("R4");
        rst_n = 1'b0;
        @(posedge clk);
        for (int l = 0; l < 2; l++) begin
            m_err[l] = 0; m_miss[l] = 0; m_irq[l] = 0;
        end
        @(negedge clk);
        rst_n = 1'b1;
        check_all("R8");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule